// File: doc/BRIEF.md
# Per-Pad Serial Configuration Cell

This cell sits beside a single I/O pad and holds the 13-bit static setup of that pad. The setup word reaches the cell over a serial daisy chain. A 13-bit shift stage accepts one bit per enabled clock. A shadow register copies the shift stage only when the load strobe is high. Because the shift stage passes its oldest bit to the serial output, cells can be chained pad after pad. A controller shifts the words for all pads through the chain, then pulses the load strobe once, and every pad takes its new setup in the same cycle.

The decoded controls come from the shadow register alone. These are the pad owner, output and input enables, the 3-bit drive mode, slew, input threshold and analog connection. The same shadow bits also steer the pad between the user-side signals and the management-side signals. The user side has an input, an output and an active-low output enable, and the management side has the same three. An active-low reset puts the shadow back to a default word, which is a parameter, and clears the shift stage.

Top module: `pad_cfg_cell`

## Requirements
- R1: On each rising clock edge with `shift_en` high, the shift stage moves up by one bit and takes `ser_in` into bit 0. `ser_out` always shows shift-stage bit 12, so a word shifted in most significant bit first comes out of `ser_out` in the same order, 13 shifts later. With `shift_en` low, the shift stage holds its value.
- R2: The shadow register, and with it every decoded pad control, changes only on a clock edge with `load` high. Shifting alone never changes the pad controls.
- R3: A clock edge with `load` high copies into the shadow the shift-stage contents from before that edge, even when `shift_en` is high on the same edge.
- R4: While `rst_n` is low, the shadow equals parameter `DEFAULT_CFG` and the shift stage is all zeros. This reset is asynchronous.
- R5: Shadow bit 0 selects the pad owner: 0 means the user side and 1 means the management side. `pad_out` and the output-enable term come from the owner's signals. `pad_in` is passed only to the owner's input, and the other side's input reads 0.
- R6: Shadow bit 1 set to 1 forces `pad_oe_n` to 1, whatever the owner drives. With bit 1 at 0, `pad_oe_n` follows the owner's active-low enable.
- R7: Shadow bit 3 set to 1 disables the input. `pad_ie_n` is 1, and both `usr_in` and `mgmt_in` read 0.
- R8: `pad_dm` equals shadow bits 12:10. `pad_dig_off` is 1 for modes 000 and 001 (analog). `pad_pullup` is 1 for modes 010 and 011 (input with pull-up). Modes 100 and 101 are open drain to power and to ground, 110 is output, and 111 is weak output.
- R9: `pad_slow` equals shadow bit 8, and `pad_in_1v8` equals shadow bit 4. `pad_lvttl` is shadow bit 9 unless bit 4 is set, in which case `pad_lvttl` is 0.
- R10: `pad_ana_en` equals shadow bit 5. `pad_ana_conn` encodes the pad connection as 0 for low rail, 1 for analog bus A, 2 for analog bus B and 3 for high rail. When shadow bit 6 equals `pad_out`, the code is 3 if `pad_out` is 1 and 0 if `pad_out` is 0. Otherwise shadow bit 7 picks between bus B (when 1) and bus A (when 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock |
| rst_n | input | 1 | Asynchronous active-low reset to default setup |
| shift_en | input | 1 | Advance the shift stage by one bit |
| load | input | 1 | Copy the shift stage into the shadow register |
| ser_in | input | 1 | Serial data from the previous cell |
| ser_out | output | 1 | Serial data to the next cell (oldest bit) |
| usr_out | input | 1 | User-side output value |
| usr_oe_n | input | 1 | User-side active-low output enable |
| usr_in | output | 1 | Pad value delivered to the user side |
| mgmt_out | input | 1 | Management-side output value |
| mgmt_oe_n | input | 1 | Management-side active-low output enable |
| mgmt_in | output | 1 | Pad value delivered to the management side |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe_n | output | 1 | Active-low pad output enable |
| pad_ie_n | output | 1 | Active-low pad input enable |
| pad_dm | output | 3 | Drive mode |
| pad_pullup | output | 1 | Input with pull-up selected |
| pad_dig_off | output | 1 | Analog drive mode, digital buffers off |
| pad_slow | output | 1 | Slow output slew |
| pad_lvttl | output | 1 | LVTTL input threshold in effect |
| pad_in_1v8 | output | 1 | 1.8 V input buffer mode |
| pad_ana_en | output | 1 | Analog buses connected |
| pad_ana_conn | output | 2 | Analog connection code |

## Verification
A shift and a load can fall on the same clock edge. The load must then capture the shift-stage word from before the edge, while the shift stage still advances. The bench fills the stage with a known word and then holds `shift_en` and `load` high together for one edge, with a chosen `ser_in` bit. It judges the result twice. It expects the pad controls of the unshifted word at once. It then issues a plain load and expects the controls of that word moved up by one bit, with the new bit at bit 0.

// File: rtl/pad_cfg_cell.sv
`timescale 1ns/1ps
module pad_cfg_cell #(
  parameter int          CFG_W       = 13,
  parameter logic [12:0] DEFAULT_CFG = 13'h0403
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       load,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic       usr_out,
  input  logic       usr_oe_n,
  output logic       usr_in,
  input  logic       mgmt_out,
  input  logic       mgmt_oe_n,
  output logic       mgmt_in,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe_n,
  output logic       pad_ie_n,
  output logic [2:0] pad_dm,
  output logic       pad_pullup,
  output logic       pad_dig_off,
  output logic       pad_slow,
  output logic       pad_lvttl,
  output logic       pad_in_1v8,
  output logic       pad_ana_en,
  output logic [1:0] pad_ana_conn
);
  localparam int B_OWN   = 0;
  localparam int B_ODIS  = 1;
  localparam int B_IDIS  = 3;
  localparam int B_V18   = 4;
  localparam int B_AEN   = 5;
  localparam int B_ASEL  = 6;
  localparam int B_APOL  = 7;
  localparam int B_SLOW  = 8;
  localparam int B_TRIP  = 9;
  localparam int B_DM_LO = 10;
  localparam int MSB     = CFG_W - 1;

  logic [MSB:0] stage_q;
  logic [MSB:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= DEFAULT_CFG[MSB:0];
    end else begin
      if (shift_en) stage_q  <= {stage_q[MSB-1:0], ser_in};
      if (load)     shadow_q <= stage_q;
    end
  end

  assign ser_out = stage_q[MSB];

  wire own_mgmt = shadow_q[B_OWN];
  wire in_ok    = ~shadow_q[B_IDIS];

  assign pad_out  = own_mgmt ? mgmt_out : usr_out;
  assign pad_oe_n = shadow_q[B_ODIS] | (own_mgmt ? mgmt_oe_n : usr_oe_n);
  assign pad_ie_n = ~in_ok;
  assign usr_in   = ~own_mgmt & in_ok & pad_in;
  assign mgmt_in  =  own_mgmt & in_ok & pad_in;

  assign pad_dm      = shadow_q[B_DM_LO +: 3];
  assign pad_pullup  = (pad_dm[2:1] == 2'b01);
  assign pad_dig_off = (pad_dm[2:1] == 2'b00);

  assign pad_slow   = shadow_q[B_SLOW];
  assign pad_in_1v8 = shadow_q[B_V18];
  assign pad_lvttl  = shadow_q[B_TRIP] & ~shadow_q[B_V18];

  assign pad_ana_en   = shadow_q[B_AEN];
  assign pad_ana_conn = (shadow_q[B_ASEL] == pad_out) ? {2{pad_out}}
                      : (shadow_q[B_APOL] ? 2'd2 : 2'd1);
endmodule

// File: rtl/pad_cfg_cell_chk.sv
`timescale 1ns/1ps
module pad_cfg_cell_chk #(
  parameter int CFG_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             load,
  input logic             ser_in,
  input logic [CFG_W-1:0] stage,
  input logic [CFG_W-1:0] shadow,
  input logic             pad_oe_n,
  input logic             usr_in,
  input logic             mgmt_in
);
  // R1
  shift_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (stage[0] == $past(ser_in)) && (stage[CFG_W-1:1] == $past(stage[CFG_W-2:0])));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage));
  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow));
  // R3
  shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shadow == $past(stage));
  // R5
  owner_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(usr_in && mgmt_in));
  // R6
  out_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow[1] |-> pad_oe_n);
  // R7
  in_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow[3] |-> (!usr_in && !mgmt_in));
endmodule

bind pad_cfg_cell pad_cfg_cell_chk #(.CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load), .ser_in(ser_in),
  .stage(stage_q), .shadow(shadow_q), .pad_oe_n(pad_oe_n),
  .usr_in(usr_in), .mgmt_in(mgmt_in)
);

// File: tb/pad_cfg_cell_tb.sv
`timescale 1ns/1ps
module pad_cfg_cell_tb_top;
  localparam logic [12:0] DEF = 13'h0403;

  logic clk = 0, rst_n = 0, shift_en = 0, load = 0, ser_in = 0;
  logic uo = 0, uoe = 1, mo = 0, moe = 1, pin = 0;
  logic ser_out, usr_in, mgmt_in, pad_out, pad_oe_n, pad_ie_n;
  logic pad_pullup, pad_dig_off, pad_slow, pad_lvttl, pad_in_1v8, pad_ana_en;
  logic [2:0] pad_dm;
  logic [1:0] pad_ana_conn;

  always #2.5 clk = ~clk;

  pad_cfg_cell #(.DEFAULT_CFG(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load),
    .ser_in(ser_in), .ser_out(ser_out),
    .usr_out(uo), .usr_oe_n(uoe), .usr_in(usr_in),
    .mgmt_out(mo), .mgmt_oe_n(moe), .mgmt_in(mgmt_in),
    .pad_in(pin), .pad_out(pad_out), .pad_oe_n(pad_oe_n), .pad_ie_n(pad_ie_n),
    .pad_dm(pad_dm), .pad_pullup(pad_pullup), .pad_dig_off(pad_dig_off),
    .pad_slow(pad_slow), .pad_lvttl(pad_lvttl), .pad_in_1v8(pad_in_1v8),
    .pad_ana_en(pad_ana_en), .pad_ana_conn(pad_ana_conn)
  );

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  logic [12:0] cfg_now;
  bit done = 0;

  function automatic logic [15:0] model(logic [12:0] c);
    logic own, po, oen, ien, ui, mi, pu, off, lv;
    logic [1:0] conn;
    own  = c[0];
    po   = own ? mo : uo;
    oen  = c[1] | (own ? moe : uoe);
    ien  = c[3];
    ui   = !own && !c[3] && pin;
    mi   = own && !c[3] && pin;
    pu   = (c[12:11] == 2'b01);
    off  = (c[12:11] == 2'b00);
    lv   = c[9] && !c[4];
    if (c[6] == po) conn = po ? 2'd3 : 2'd0;
    else            conn = c[7] ? 2'd2 : 2'd1;
    return {po, oen, ien, ui, mi, c[12:10], pu, off, c[8], lv, c[4], c[5], conn};
  endfunction

  function automatic logic [15:0] actual();
    return {pad_out, pad_oe_n, pad_ie_n, usr_in, mgmt_in, pad_dm, pad_pullup,
            pad_dig_off, pad_slow, pad_lvttl, pad_in_1v8, pad_ana_en, pad_ana_conn};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, actual(), it.exp);
    end
  end

  task automatic expect_now(string tag);
    item_t it;
    it.tag = tag;
    it.exp = model(cfg_now);
    q.push_back(it);
  endtask

  task automatic set_io(logic a, logic b, logic c, logic d, logic p, string tag);
    @(negedge clk);
    uo = a; uoe = b; mo = c; moe = d; pin = p;
    expect_now(tag);
  endtask

  task automatic shift_word(logic [12:0] w, bit chk_out, logic [12:0] prev);
    for (int i = 12; i >= 0; i--) begin
      @(negedge clk);
      if (chk_out) chk("R1 ser_out", {15'd0, ser_out}, {15'd0, prev[i]});
      ser_in = w[i]; shift_en = 1;
    end
    @(negedge clk);
    shift_en = 0;
  endtask

  task automatic do_load(logic [12:0] w, string tag);
    @(negedge clk);
    load = 1;
    @(posedge clk);
    cfg_now = w;
    expect_now(tag);
    @(negedge clk);
    load = 0;
  endtask

  task automatic load_word(logic [12:0] w, string tag);
    shift_word(w, 0, '0);
    do_load(w, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_now = DEF;
    // R4 reset state
    expect_now("R4 reset default");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 stage cleared", {15'd0, ser_out}, 16'd0);

    // R5 user owner drives
    set_io(1, 0, 0, 1, 1, "R5 io set");
    load_word(13'h1808, "R5 user output");
    set_io(0, 1, 1, 0, 1, "R5 user oe_n off");
    set_io(1, 0, 1, 0, 0, "R5 user pin low");
    // R5 R7 management owner, input disabled
    load_word(13'h1809, "R7 mgmt input disabled");
    set_io(0, 1, 1, 0, 1, "R5 mgmt drives");
    // R6 output disable forces oe_n
    load_word(13'h0c03, "R6 forced off R8 pullup");
    load_word(13'h1801, "R6 mgmt bidir");
    load_word(13'h0c02, "R5 user input pullup");
    // R8 all drive modes
    for (int m = 0; m < 8; m++) load_word({m[2:0], 10'h000}, "R8 drive mode");
    // R9 slew and trip
    load_word(13'h0300, "R9 slow lvttl");
    load_word(13'h0310, "R9 1v8 overrides");
    load_word(13'h0210, "R9 1v8 only");
    // R10 analog connection
    for (int k = 0; k < 8; k++) begin
      set_io(k[2], 0, 0, 1, 0, "R10 io");
      load_word({3'b000, 2'b00, k[1], k[0], 1'b1, 5'b00000}, "R10 analog conn");
    end
    // R2 shifting alone does not touch controls
    set_io(1, 0, 0, 1, 1, "R2 io");
    shift_word(13'h1ff3, 0, '0);
    expect_now("R2 held during shift");
    @(negedge clk);
    // R1 ser_out carries the previous word out MSB first
    shift_word(13'h0a5c, 1, 13'h1ff3);
    do_load(13'h0a5c, "R1 loaded after chain");
    // R3 simultaneous shift and load
    shift_word(13'h1b26, 0, '0);
    @(negedge clk);
    load = 1; shift_en = 1; ser_in = 1;
    @(posedge clk);
    cfg_now = 13'h1b26;
    expect_now("R3 load with shift");
    @(negedge clk);
    load = 0; shift_en = 0;
    do_load({13'h1b26 << 1} | 13'h0001, "R3 shifted word");
    // R4 mid-run reset
    @(negedge clk);
    rst_n = 0;
    cfg_now = DEF;
    expect_now("R4 async reset");
    @(negedge clk);
    rst_n = 1;
    do_load(13'h0000, "R4 stage zero after reset");

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule